// File: doc/BRIEF.md
# Sync Pulse Rate Decimator

This block receives an external sync signal in the fast converter clock domain and turns it into an internal sync pulse with a fixed period of 32 clock cycles. The external pulses may arrive at any of five rates, from one per 32 clocks down to one per 2 clocks. A 3-bit rate code tells the block which rate to expect. When the input is faster than one per 32 clocks, the block keeps one pulse per frame and throws away the rest.

The input first passes through a two-flop synchroniser. A rising-edge detector follows, so a high level of any length counts as a single pulse. The first edge seen after reset, or after the rate code changes, starts the 32-cycle frame. From then on a free-running frame counter emits the output pulse. Every later input edge is compared with the slot where it should fall. An edge in the wrong slot sets a sticky misalignment flag, which stays set until a clear input is pulsed. Rate codes with no defined rate raise an error flag, and the block keeps its output quiet while such a code is selected.

Top module: `sync_rate_thinner`

## Requirements
- R1: While reset is asserted, and once it is released with no input edge, `sync_out`, `rate_err` and `misalign` are all 0. The stored rate code resets to 000.
- R2: Rate code c in the range 000 to 100 declares an input period of 32>>c cycles (000=32, 001=16, 010=8, 011=4, 100=2) and raises no error. At each of these rates an aligned input stream produces correct frames and no misalignment.
- R3: Rate codes 101, 110 and 111 set `rate_err` one cycle after they are applied. While such a code is held, `sync_out` stays 0 whatever `sync_in` does. `rate_err` returns to 0 one cycle after a valid code is applied.
- R4: The first input edge after reset or after a rate change starts a frame. If `sync_in` is first sampled high on clock edge k, `sync_out` is high for exactly the cycle after clock edge k+2.
- R5: While locked, `sync_out` pulses for one cycle every 32 cycles, measured from the starting pulse, and never pulses in two cycles in a row.
- R6: At rates faster than one per 32 clocks, the input edges between frame starts are dropped. At 001 every second input pulse is discarded, and the output period stays 32.
- R7: Pulses are recognised by their rising edge only. A high level lasting from one cycle up to many cycles counts as one pulse.
- R8: A change of the rate code unlocks the frame, with the last frame pulse possible one cycle after the change. The next input edge then restarts the frame at its own position.
- R9: An input edge in a slot that is not a multiple of the declared period, or a frame-start edge that does not land at the frame boundary, sets `misalign`. The flag stays set until it is cleared.
- R10: A high level on `misalign_clr` clears `misalign` on the next clock edge, unless a misplaced edge is seen in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in | input | 1 | External sync pulse, asynchronous to clk |
| rate_code | input | 3 | Declared input sync rate code |
| misalign_clr | input | 1 | Write-one-to-clear for the misalignment flag |
| sync_out | output | 1 | Internal sync pulse, one cycle wide, 32-cycle period |
| rate_err | output | 1 | Selected rate code is undefined |
| misalign | output | 1 | Sticky flag: an input edge was out of place |

## Verification
An input sampled high on clock edge k shows up on `sync_out` after edge k+2. Each later frame pulse follows 32 cycles after the one before. The driver records the cycle number of the first rising edge it applies and queues every frame pulse it expects, up to one cycle past the next rate change. The monitor pops these entries on the falling edge of the cycle they name, and flags both early and missing pulses. `rate_err` and a cleared `misalign` are due one cycle after the input that causes them, so they are sampled on the next falling edge. A misplaced edge is judged only after the stream has ended, well past its three-cycle path.

// File: rtl/sync_thin_pkg.sv
package sync_thin_pkg;

  // Lock state of the frame tracker
  typedef enum logic {
    TRK_IDLE   = 1'b0,
    TRK_LOCKED = 1'b1
  } trk_state_e;

endpackage

// File: rtl/sync_edge_capture.sv
// Multi-stage synchroniser followed by a rising-edge detector.
module sync_edge_capture #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              hist_q;
  logic              hist_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = din;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], din};
    end
  endgenerate

  always_comb hist_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~hist_q;

  // R7: a level is reported as one edge, never on back-to-back cycles
  assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sync_rate_decode.sv
// Turns the rate code into a slot mask (period-1) and an edge-index mask
// (edges per frame - 1). Codes at or above CNT_W are undefined.
module sync_rate_decode #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 5
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [CNT_W-1:0]  slot_mask_o,
  output logic [CNT_W-1:0]  edge_mask_o
);

  localparam int               FRAME_LEN = 1 << CNT_W;
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(CNT_W - 1);

  always_comb begin
    valid_o = (code_i <= MAX_CODE);
    if (valid_o) begin
      slot_mask_o = {CNT_W{1'b1}} >> code_i;
      edge_mask_o = ~({CNT_W{1'b1}} << code_i);
    end else begin
      slot_mask_o = '0;
      edge_mask_o = '0;
    end
  end

  // R2: period times edges per frame always equals the frame length
  always_comb begin
    if (valid_o) begin
      assert_mask_pair_R2: assert ((int'(slot_mask_o) + 1) * (int'(edge_mask_o) + 1) == FRAME_LEN);
    end
  end

endmodule

// File: rtl/sync_frame_tracker.sv
// Locks onto the first edge, runs the 32-cycle frame, decides which edges
// are kept and flags misplaced ones.
module sync_frame_tracker
  import sync_thin_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             rate_chg_i,
  input  logic             rate_ok_i,
  input  logic [CNT_W-1:0] slot_mask_i,
  input  logic [CNT_W-1:0] edge_mask_i,
  input  logic             mis_clr_i,
  output logic             pulse_o,
  output logic             mis_o
);

  trk_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] eidx_q, eidx_d;
  logic             pulse_q, pulse_d;
  logic             mis_q, mis_d;
  logic             cnt_en, eidx_en, mis_set;
  logic             cnt_zero, off_grid, kept;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    off_grid = |(cnt_q & slot_mask_i);
    kept     = ((eidx_q & edge_mask_i) == '0);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    eidx_d  = eidx_q;
    pulse_d = 1'b0;
    cnt_en  = 1'b0;
    eidx_en = 1'b0;
    mis_set = 1'b0;
    case (state_q)
      TRK_IDLE: begin
        if (rise_i && rate_ok_i && !rate_chg_i) begin
          state_d = TRK_LOCKED;
          cnt_en  = 1'b1;
          cnt_d   = CNT_W'(1);
          eidx_en = 1'b1;
          eidx_d  = CNT_W'(1) & edge_mask_i;
          pulse_d = 1'b1;
        end
      end
      TRK_LOCKED: begin
        pulse_d = cnt_zero;
        cnt_en  = 1'b1;
        if (rate_chg_i) begin
          state_d = TRK_IDLE;
          cnt_d   = '0;
          eidx_en = 1'b1;
          eidx_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
          if (rise_i) begin
            eidx_en = 1'b1;
            eidx_d  = (eidx_q + 1'b1) & edge_mask_i;
            mis_set = off_grid | (kept ^ cnt_zero);
          end
        end
      end
      default: state_d = TRK_IDLE;
    endcase
    if (mis_set)        mis_d = 1'b1;
    else if (mis_clr_i) mis_d = 1'b0;
    else                mis_d = mis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
      cnt_q   <= '0;
      eidx_q  <= '0;
      pulse_q <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      mis_q   <= mis_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (eidx_en) eidx_q <= eidx_d;
    end
  end

  assign pulse_o = pulse_q;
  assign mis_o   = mis_q;

  // R5: the output pulse is one cycle wide
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R4: a pulse out of the idle state comes from an input edge
  assert_first_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && $past(state_q) == TRK_IDLE) |-> $past(rise_i));

  // R3: no pulse follows a cycle with an undefined rate code
  assert_invalid_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_ok_i |=> !pulse_q);

  // R9: the misalignment flag holds until cleared
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_q && !mis_clr_i) |=> mis_q);

  // R10: a clear with no competing edge empties the flag
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_clr_i && !rise_i) |=> !mis_q);

endmodule

// File: rtl/sync_rate_thinner.sv
// Top: reset release synchroniser, rate code register, capture, decode
// and frame tracking. FRAME_LEN must be a power of two.
module sync_rate_thinner #(
  parameter int RATE_W      = 3,
  parameter int FRAME_LEN   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              misalign_clr,
  output logic              sync_out,
  output logic              rate_err,
  output logic              misalign
);

  localparam int CNT_W = $clog2(FRAME_LEN);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [RATE_W-1:0] rate_q;
  logic              rate_chg;
  logic              rate_ok;
  logic [CNT_W-1:0]  slot_mask;
  logic [CNT_W-1:0]  edge_mask;
  logic              rise;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  always_comb rate_chg = (rate_code != rate_q);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)    rate_q <= '0;
    else if (rate_chg) rate_q <= rate_code;
  end

  sync_edge_capture #(.STAGES(SYNC_STAGES)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .din    (sync_in),
    .rise_o (rise)
  );

  sync_rate_decode #(.CODE_W(RATE_W), .CNT_W(CNT_W)) u_decode (
    .code_i      (rate_q),
    .valid_o     (rate_ok),
    .slot_mask_o (slot_mask),
    .edge_mask_o (edge_mask)
  );

  sync_frame_tracker #(.CNT_W(CNT_W)) u_tracker (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .rise_i      (rise),
    .rate_chg_i  (rate_chg),
    .rate_ok_i   (rate_ok),
    .slot_mask_i (slot_mask),
    .edge_mask_i (edge_mask),
    .mis_clr_i   (misalign_clr),
    .pulse_o     (sync_out),
    .mis_o       (misalign)
  );

  assign rate_err = ~rate_ok;

endmodule

// File: tb/sync_rate_thinner_bench.sv
module sync_rate_thinner_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_in;
  logic [2:0] rate_code;
  logic       misalign_clr;
  logic       sync_out;
  logic       rate_err;
  logic       misalign;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sync_rate_thinner u_sync_rate_thinner (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_in      (sync_in),
    .rate_code    (rate_code),
    .misalign_clr (misalign_clr),
    .sync_out     (sync_out),
    .rate_err     (rate_err),
    .misalign     (misalign)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Scoreboard monitor: compares pulses with the queued cycle numbers
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0] < cyc) begin
      total++;
      bad++;
      $display("FAIL R5: actual=no pulse expected=pulse at cycle %0d", exp_q[0]);
      void'(exp_q.pop_front());
    end
    if (sync_out) begin
      total++;
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        void'(exp_q.pop_front());
      end else begin
        bad++;
        $display("FAIL R6: actual=pulse at cycle %0d expected=%0d", cyc,
                 (exp_q.size() > 0) ? exp_q[0] : -1);
      end
    end
  end

  // R4/R5: first pulse three edges after the first sample, then every 32
  task automatic push_frames(input int c0, input int lim);
    for (int t = c0 + 3; t <= lim; t += 32) exp_q.push_back(t);
  endtask

  // Drives len cycles of a pulse train, idles gap cycles, then applies
  // next_code on the last idle cycle.
  task automatic stream(input int period, input int high, input int len, input int gap,
                        input logic [2:0] next_code, input bit track, input int late_slot);
    int c0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin
        c0 = cyc;
        if (track) push_frames(c0, c0 + len + gap);
      end
      if (late_slot >= 0 && (i / period) == late_slot)
        sync_in = ((i % period) >= 3) && ((i % period) < 3 + high);
      else
        sync_in = (i % period) < high;
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      sync_in = 1'b0;
      if (g == gap - 1) rate_code = next_code;
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sync_in = 1'b0;
    rate_code = 3'b000;
    misalign_clr = 1'b0;
    repeat (3) @(negedge clk);
    check(sync_out == 1'b0, "R1", sync_out, 0);
    check(rate_err == 1'b0, "R1", rate_err, 0);
    check(misalign == 1'b0, "R1", misalign, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sync_out == 1'b0 && rate_err == 1'b0 && misalign == 1'b0, "R1",
          {sync_out, rate_err, misalign}, 0);

    // R7: 000, long high level counted once; R4 start of frame
    stream(32, 20, 128, 6, 3'b001, 1'b1, -1);
    @(negedge clk);
    check(rate_err == 1'b0, "R2", rate_err, 0);
    check(misalign == 1'b0, "R7", misalign, 0);

    // R6: 001, every second input pulse dropped; R8 relock after change
    stream(16, 1, 128, 6, 3'b100, 1'b1, -1);
    @(negedge clk);
    check(misalign == 1'b0, "R6", misalign, 0);

    // R2: 100, minimum width pulses every two cycles
    stream(2, 1, 128, 6, 3'b011, 1'b1, -1);
    @(negedge clk);
    check(misalign == 1'b0, "R2", misalign, 0);

    // R7: 011 with three-cycle highs, then undefined code 101
    stream(4, 3, 128, 6, 3'b101, 1'b1, -1);
    @(negedge clk);
    check(misalign == 1'b0, "R7", misalign, 0);
    check(rate_err == 1'b1, "R3", rate_err, 1);

    // R3: pulses while undefined produce no output
    stream(8, 2, 64, 6, 3'b110, 1'b0, -1);
    @(negedge clk);
    check(rate_err == 1'b1, "R3", rate_err, 1);
    stream(8, 2, 32, 4, 3'b111, 1'b0, -1);
    @(negedge clk);
    check(rate_err == 1'b1, "R3", rate_err, 1);
    rate_code = 3'b010;
    @(negedge clk);
    check(rate_err == 1'b0, "R3", rate_err, 0);
    repeat (4) @(negedge clk);
    check(misalign == 1'b0, "R9", misalign, 0);

    // R9: 010 stream with one pulse late by three cycles
    stream(8, 2, 128, 6, 3'b000, 1'b1, 5);
    @(negedge clk);
    check(misalign == 1'b1, "R9", misalign, 1);
    repeat (5) @(negedge clk);
    check(misalign == 1'b1, "R9", misalign, 1);
    misalign_clr = 1'b1;
    @(negedge clk);
    misalign_clr = 1'b0;
    check(misalign == 1'b0, "R10", misalign, 0);

    // R8: relock at a new phase with code 000, then unlock
    repeat (7) @(negedge clk);
    stream(32, 1, 96, 6, 3'b001, 1'b1, -1);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    check(misalign == 1'b0, "R8", misalign, 0);

    finish_run();
  end

endmodule